// File: doc/BRIEF.md
# Word-serial shift-and-add rotation engine

This block evaluates rotations and vector-to-angle reductions in three coordinate systems (circular, linear and hyperbolic). It keeps x, y and z in registers and does one shift-and-add micro-rotation per clock. Each step shifts x and y right by the step's shift amount, adds or subtracts the results, and moves z by an elementary angle read from a small constant table. Only one adder path is used per variable, so several dozen cycles of multiply-free arithmetic take the place of four multipliers.

A caller presents signed fixed-point operands and pulses `start`. It then waits for the one-cycle `done` pulse and reads the three outputs. All data are two's complement with 14 fraction bits, and angles are in radians. In rotation mode, z carries the angle to turn through. In vectoring mode, the vector is driven onto the positive x-axis and the angle it swept is accumulated in z. An optional extra cycle multiplies x and y by the inverse of the system's accumulated gain.

Top module: `cordic_iter`

## Requirements
- R1: After reset, `busy` and `done` are low and `x_out`, `y_out` and `z_out` are zero.
- R2: When `busy` is low, a high `start` is accepted at a clock edge and `busy` rises. The `coord` input selects the system: 2'b00 is circular, 2'b10 is hyperbolic, and 2'b01 or 2'b11 is linear. `vec` = 0 selects rotation and `vec` = 1 selects vectoring.
- R3: In circular rotation with the gain pass, the result is (x·cos z − y·sin z, y·cos z + x·sin z), and z ends near 0. Without the pass, x and y are also scaled by the circular gain (the product of sqrt(1+2^−2i) over the steps taken).
- R4: In vectoring in any system, z starts from zero and `z_in` has no effect. y is driven to near 0. Circular vectoring with gain gives x = sqrt(x²+y²) and z = atan(y/x).
- R5: In linear rotation, x is unchanged and y becomes y + x·z. In linear vectoring, z becomes y/x and y goes to near 0.
- R6: In hyperbolic rotation with gain, the result is (x·cosh z + y·sinh z, y·cosh z + x·sinh z). In hyperbolic vectoring with gain, x becomes sqrt(x²−y²) and z becomes atanh(y/x). Without gain, x and y are scaled by the product of sqrt(1−2^−2s) over the shifts used.
- R7: Circular and linear runs take N steps, using shifts 0 to N−1. Hyperbolic runs use shifts 1 to N, with shifts 4 and 13 each done twice. `done` rises that many edges after the edge that accepted `start`. With the default N = 14, this is 14, 14 and 16 edges.
- R8: With `gain_en` high, circular and hyperbolic runs take one extra edge for gain correction. Linear runs ignore `gain_en`.
- R9: `done` is high for exactly one cycle, and in that cycle `busy` is already low.
- R10: A `start` pulse while `busy` is high is ignored. It neither changes the running result nor its `done` time, and it produces no additional `done`.
- R11: After `done`, the outputs hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| coord | input | 2 | Coordinate system select |
| vec | input | 1 | 0 rotation, 1 vectoring |
| gain_en | input | 1 | Enable gain correction pass |
| x_in | input | W | Initial x |
| y_in | input | W | Initial y |
| z_in | input | W | Initial angle (rotation only) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | W | Result x |
| y_out | output | W | Result y |
| z_out | output | W | Result z |

## Verification
With N = 14, each result is due a fixed number of edges after the edge that takes `start`:
- 14 for circular or linear work;
- 16 for hyperbolic work;
- one more when gain correction applies to a circular or hyperbolic run.

The driver stamps the time at which it raises `start` and queues that time with the expected values. The monitor samples on falling edges, pops the entry when `done` appears and turns the elapsed time into an edge count, which it compares with the queued latency. A `done` with nothing queued, for example one caused by a `start` the block should have ignored, counts as a failure.

// File: rtl/cordic_iter.sv
`timescale 1ns/1ps
module cordic_iter #(
  parameter int W = 18,
  parameter int N = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          coord,
  input  logic                vec,
  input  logic                gain_en,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] z_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] z_out
);
  localparam int FR = 14;
  localparam int SW = $clog2(N + 2);
  localparam logic [SW-1:0] LAST_H = SW'(N);
  localparam logic [SW-1:0] LAST_C = SW'(N - 1);
  localparam logic signed [16:0] GC_CIRC = 17'sd9949;
  localparam logic signed [16:0] GC_HYP  = 17'sd19784;

  typedef enum logic [1:0] {IDLE, RUN, GAIN} st_t;

  st_t st;
  logic [1:0] cs;
  logic vm, ge, rep;
  logic [SW-1:0] sh;
  logic signed [W-1:0] xr, yr, zr;

  function automatic logic signed [W-1:0] elem(input logic [1:0] c, input logic [SW-1:0] s);
    logic [15:0] v;
    v = 16'd16384 >> s;
    if (c == 2'b10) begin
      case (s)
        1: v = 16'd9000;
        2: v = 16'd4185;
        3: v = 16'd2059;
        4: v = 16'd1025;
        default: ;
      endcase
    end else if (!c[0]) begin
      case (s)
        0: v = 16'd12868;
        1: v = 16'd7596;
        2: v = 16'd4014;
        3: v = 16'd2037;
        4: v = 16'd1023;
        default: ;
      endcase
    end
    return $signed({{(W-16){1'b0}}, v});
  endfunction

  wire hyp = (cs == 2'b10);
  wire lin = cs[0];
  wire dpos = vm ? (xr[W-1] ^ yr[W-1]) : ~zr[W-1];
  wire signed [W-1:0] xs = xr >>> sh;
  wire signed [W-1:0] ys = yr >>> sh;
  wire signed [W-1:0] ang = elem(cs, sh);
  wire need_rep = hyp && (sh == SW'(4) || sh == SW'(13)) && !rep;
  wire last = (sh == (hyp ? LAST_H : LAST_C)) && !need_rep;

  logic signed [W-1:0] xn;
  always_comb begin
    if (lin)       xn = xr;
    else if (hyp)  xn = dpos ? xr + ys : xr - ys;
    else           xn = dpos ? xr - ys : xr + ys;
  end
  wire signed [W-1:0] yn = dpos ? yr + xs : yr - xs;
  wire signed [W-1:0] zn = dpos ? zr - ang : zr + ang;

  wire signed [16:0] gc = hyp ? GC_HYP : GC_CIRC;
  wire signed [W+16:0] px = xr * gc;
  wire signed [W+16:0] py = yr * gc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; cs <= 2'b00; vm <= 1'b0; ge <= 1'b0;
      rep <= 1'b0; sh <= '0; xr <= '0; yr <= '0; zr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          cs  <= coord;
          vm  <= vec;
          ge  <= gain_en && !coord[0];
          xr  <= x_in;
          yr  <= y_in;
          zr  <= vec ? '0 : z_in;
          sh  <= (coord == 2'b10) ? SW'(1) : '0;
          rep <= 1'b0;
          st  <= RUN;
        end
        RUN: begin
          xr <= xn; yr <= yn; zr <= zn;
          if (need_rep) rep <= 1'b1;
          else begin sh <= sh + 1'b1; rep <= 1'b0; end
          if (last) begin
            if (ge) st <= GAIN;
            else begin st <= IDLE; done <= 1'b1; end
          end
        end
        default: begin
          xr <= px[FR+W-1:FR];
          yr <= py[FR+W-1:FR];
          st <= IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  assign busy  = (st != IDLE);
  assign x_out = xr;
  assign y_out = yr;
  assign z_out = zr;
endmodule

// File: rtl/cordic_iter_chk.sv
`timescale 1ns/1ps
module cordic_iter_chk #(
  parameter int N = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] cs,
  input logic       ge
);
  localparam int HSTEPS = N + ((N >= 4) ? 1 : 0) + ((N >= 13) ? 1 : 0);
  int cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else if (start && !busy) cnt <= 0;
    else if (busy) cnt <= cnt + 1;
  end
  wire [31:0] due = 32'((cs == 2'b10) ? HSTEPS : N) + 32'(ge ? 1 : 0);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (32'(cnt) == due));
  // R8
  lin_nogain_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && cs[0]) |-> !ge);
endmodule

bind cordic_iter cordic_iter_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .cs(cs), .ge(ge)
);

// File: tb/cordic_iter_bench.sv
`timescale 1ns/1ps
module cordic_iter_bench;
  localparam int W = 18;
  localparam int N = 14;
  localparam real SC = 16384.0;
  localparam real TOL = 0.004;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, vec = 1'b0, gain_en = 1'b0;
  logic [1:0] coord = 2'b00;
  logic signed [W-1:0] x_in = '0, y_in = '0, z_in = '0;
  logic busy, done;
  logic signed [W-1:0] x_out, y_out, z_out;

  cordic_iter #(.W(W), .N(N)) u_cordic_iter (
    .clk(clk), .rst_n(rst_n), .start(start), .coord(coord), .vec(vec), .gain_en(gain_en),
    .x_in(x_in), .y_in(y_in), .z_in(z_in), .busy(busy), .done(done),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    string tag;
    real ex, ey, ez;
    int lat;
    time t0;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  real kc = 1.0, kh = 1.0;
  logic signed [W-1:0] hx, hy, hz;

  function automatic real fx(input logic signed [W-1:0] v);
    return $itor(v) / SC;
  endfunction

  task automatic chk_r(input string req, input string what, input real act, input real ex);
    checks++;
    if ((act - ex) > TOL || (ex - act) > TOL) begin
      fails++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, ex);
    end
  endtask

  task automatic chk_i(input string req, input string what, input int act, input int ex);
    checks++;
    if (act != ex) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, ex);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      hx = x_out; hy = y_out; hz = z_out;
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected done: actual 1 expected 0");
      end else begin
        exp_t it;
        it = sb.pop_front();
        chk_r(it.tag, "x", fx(x_out), it.ex);
        chk_r(it.tag, "y", fx(y_out), it.ey);
        chk_r(it.tag, "z", fx(z_out), it.ez);
        chk_i("R7", {it.tag, " latency"}, int'(($time - it.t0) / 10) - 1, it.lat);
        chk_i("R9", {it.tag, " busy at done"}, int'(busy), 0);
      end
    end
  end

  task automatic drive(input string tag, input logic [1:0] c, input logic v, input logic g,
                       input real xi, input real yi, input real zi,
                       input real ex, input real ey, input real ez, input int lat);
    exp_t it;
    while (busy) @(negedge clk);
    coord = c; vec = v; gain_en = g;
    x_in = W'($rtoi(xi * SC)); y_in = W'($rtoi(yi * SC)); z_in = W'($rtoi(zi * SC));
    it.tag = tag; it.ex = ex; it.ey = ey; it.ez = ez; it.lat = lat; it.t0 = $time;
    sb.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) kc = kc * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    for (int s = 1; s <= N; s++) begin
      kh = kh * $sqrt(1.0 - 2.0 ** (-2.0 * s));
      if (s == 4 || s == 13) kh = kh * $sqrt(1.0 - 2.0 ** (-2.0 * s));
    end
    repeat (3) @(negedge clk);
    // R1
    chk_i("R1", "busy", int'(busy), 0);
    chk_i("R1", "done", int'(done), 0);
    chk_i("R1", "x_out", int'(x_out), 0);
    chk_i("R1", "z_out", int'(z_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 rotation with gain, 30 degrees
    drive("R3", 2'b00, 1'b0, 1'b1, 1.0, 0.0, 0.5235988, $cos(0.5235988), $sin(0.5235988), 0.0, N + 1);
    settle();
    // R3 rotation without gain, scaled
    drive("R3", 2'b00, 1'b0, 1'b0, 0.5, 0.25, -1.0,
          kc * (0.5 * $cos(-1.0) - 0.25 * $sin(-1.0)), kc * (0.25 * $cos(-1.0) + 0.5 * $sin(-1.0)), 0.0, N);
    settle();
    // R4 vectoring, z_in must be ignored
    drive("R4", 2'b00, 1'b1, 1'b1, 0.6, 0.8, 3.0, 1.0, 0.0, $atan2(0.8, 0.6), N + 1);
    settle();
    drive("R4", 2'b00, 1'b1, 1'b1, 1.0, -1.0, -2.0, $sqrt(2.0), 0.0, -0.7853982, N + 1);
    settle();
    // R5 linear rotation, R8 gain_en ignored for linear
    drive("R5", 2'b01, 1'b0, 1'b1, 1.5, 0.25, 0.75, 1.5, 1.375, 0.0, N);
    settle();
    // R5 linear vectoring with coord 2'b11
    drive("R5", 2'b11, 1'b1, 1'b0, 2.0, 1.0, 1.0, 2.0, 0.0, 0.5, N);
    settle();
    // R6 hyperbolic rotation with gain (R8 extra edge)
    drive("R6", 2'b10, 1'b0, 1'b1, 1.0, 0.0, 0.5, $cosh(0.5), $sinh(0.5), 0.0, N + 3);
    settle();
    // R6 hyperbolic vectoring with gain
    drive("R6", 2'b10, 1'b1, 1'b1, 1.0, 0.5, 0.0, $sqrt(0.75), 0.0, 0.5 * $ln(3.0), N + 3);
    settle();
    // R6 hyperbolic rotation without gain
    drive("R6", 2'b10, 1'b0, 1'b0, 1.0, 0.0, -0.4, kh * $cosh(-0.4), kh * $sinh(-0.4), 0.0, N + 2);
    settle();
    // R11 outputs hold after done
    chk_i("R11", "x hold", int'(x_out), int'(hx));
    chk_i("R11", "y hold", int'(y_out), int'(hy));
    chk_i("R11", "z hold", int'(z_out), int'(hz));

    // R10 start during busy is ignored
    drive("R10", 2'b00, 1'b0, 1'b1, 1.0, 0.0, 0.7, $cos(0.7), $sin(0.7), 0.0, N + 1);
    repeat (3) @(negedge clk);
    coord = 2'b01; vec = 1'b1; gain_en = 1'b0;
    x_in = W'($rtoi(0.3 * SC)); y_in = W'($rtoi(-0.9 * SC)); z_in = W'($rtoi(1.2 * SC));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle();
    repeat (20) @(negedge clk);
    chk_i("R10", "idle after ignored start", int'(busy), 0);
    chk_r("R11", "x after ignored start", fx(x_out), $cos(0.7));

    summary();
  end
endmodule